// File: doc/BRIEF.md
# CAN Fault Confinement Counter Unit

This unit keeps the fault-confinement state of a single CAN node: an 8-bit transmit error counter, an 8-bit receive error counter, a bus-off flag and a reset-mode flag. The protocol engine around it reports what happened on the bus as single-cycle strobes. These are a transmit or receive error, a successful transmit or receive, and a bit-time tick together with the sampled bus level. Each error strobe adds one to its counter. Each success strobe takes one away.

A transmit error that arrives while the transmit counter is at 255 drives the node into bus-off. The receive counter is then cleared, the transmit counter is loaded with 127, and reset mode is raised. Optional one-cycle interrupt pulses mark the entry. Software ends reset mode with a clear strobe, and only then does recovery begin. The unit counts runs of 11 recessive bit times. Each completed run lowers the transmit counter by one, and the 128th run returns the node to error-active operation.

Top module: `canFaultConf`

## Requirements
- R1: After reset both counters read 0 and busOff, resetMode, busErrIrq and errIrq are all 0.
- R2: While neither busOff nor resetMode is set, txErr and rxErr each add 1 to their counter, and txOk and rxOk each subtract 1. A decrement at 0 leaves 0, and rxCnt holds at 255. If the error and success strobes for the same counter arrive in the same cycle, the error wins. The result is visible one clock after the strobe.
- R3: A txErr while txCnt is 255 causes, one clock later, busOff=1, resetMode=1, txCnt=127 and rxCnt=0. At txCnt=254 a txErr only gives 255.
- R4: busErrIrq and errIrq are each high for exactly one cycle, in the cycle in which busOff first reads 1. Each pulse appears only if its enable (ieBusErr, ieErr) was high with the entering error.
- R5: While busOff or resetMode is 1, the strobes txErr, rxErr, txOk and rxOk change neither counter.
- R6: clrResetMode clears resetMode one clock later. When resetMode is already 0, it changes no output.
- R7: With busOff=1 and resetMode=0, every 11th consecutive bitTick that samples busLevel=1 (recessive) lowers txCnt by 1, holding at 0. While resetMode=1, bitTick has no effect.
- R8: A bitTick with busLevel=0 (dominant) during recovery restarts the count of 11 recessive bits.
- R9: At the end of the 128th such run, busOff returns to 0 with txCnt=0, and the error strobes count normally again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txErr | input | 1 | Transmit error strobe |
| rxErr | input | 1 | Receive error strobe |
| txOk | input | 1 | Successful transmit strobe |
| rxOk | input | 1 | Successful receive strobe |
| bitTick | input | 1 | One pulse per bit time |
| busLevel | input | 1 | Sampled bus level, 1 = recessive |
| clrResetMode | input | 1 | Software clear of the reset-mode flag |
| ieBusErr | input | 1 | Enable for busErrIrq |
| ieErr | input | 1 | Enable for errIrq |
| txCnt | output | 8 | Transmit error counter |
| rxCnt | output | 8 | Receive error counter |
| busOff | output | 1 | Node is bus-off |
| resetMode | output | 1 | Reset mode flag |
| busErrIrq | output | 1 | Bus-error interrupt pulse |
| errIrq | output | 1 | Error interrupt pulse |

## Verification
The state that is hardest to reach is the end of recovery. Getting there takes a transmit counter driven to 255 and then past it. After that, software must clear reset mode, and 128 runs of 11 recessive ticks must follow. The stimulus pushes 255 transmit errors and then one more with an enable set. It interrupts one run with a dominant tick and feeds unbroken runs until the final run completes. Along the way it checks the counter at 127, at 126, at 0 with bus-off still set, and after the exit.

// File: rtl/canFcPkg.sv
package canFcPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic countEn;      // error-active: strobes update counters
    logic recovEn;      // bus-off with reset mode cleared: count bus-free runs
    logic enterBusOff;  // load bus-off values this cycle
  } fcCtrl_t;
endpackage

// File: rtl/canFcData.sv
module canFcData
  import canFcPkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int BUS_FREE_BITS = 11,
  parameter int RECOVER_SEQS  = 128,
  parameter int BUSOFF_LOAD   = 127
) (
  input  logic             clk,
  input  logic             rstN,
  input  fcCtrl_t          ctrl,
  input  logic             txErr,
  input  logic             rxErr,
  input  logic             txOk,
  input  logic             rxOk,
  input  logic             bitTick,
  input  logic             busLevel,
  output logic [CNT_W-1:0] txCnt,
  output logic [CNT_W-1:0] rxCnt,
  output logic             txAtMax,
  output logic             lastSeqDone
);
  localparam int RUN_W = (BUS_FREE_BITS > 1) ? $clog2(BUS_FREE_BITS) : 1;
  localparam int SEQ_W = (RECOVER_SEQS > 1) ? $clog2(RECOVER_SEQS) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(BUS_FREE_BITS - 1);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(RECOVER_SEQS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSOFF_LOAD);

  logic [RUN_W-1:0] runCnt, runNext;
  logic [SEQ_W-1:0] seqCnt, seqNext;
  logic [CNT_W-1:0] txNext, rxNext;
  logic             seqEnd;

  assign txAtMax     = (txCnt == CNT_MAX);
  assign seqEnd      = ctrl.recovEn && bitTick && busLevel && (runCnt == RUN_LAST);
  assign lastSeqDone = seqEnd && (seqCnt == SEQ_LAST);

  // recessive run counter
  always_comb begin
    runNext = runCnt;
    if (!ctrl.recovEn)      runNext = '0;
    else if (bitTick) begin
      if (!busLevel)        runNext = '0;
      else if (seqEnd)      runNext = '0;
      else                  runNext = runCnt + 1'b1;
    end
  end

  // completed bus-free sequence counter
  always_comb begin
    seqNext = seqCnt;
    if (!ctrl.recovEn)      seqNext = '0;
    else if (seqEnd)        seqNext = (seqCnt == SEQ_LAST) ? '0 : seqCnt + 1'b1;
  end

  // transmit counter
  always_comb begin
    txNext = txCnt;
    if (ctrl.enterBusOff)             txNext = LOAD_VAL;
    else if (ctrl.countEn) begin
      if (txErr)                      txNext = txCnt + 1'b1;
      else if (txOk && txCnt != '0)   txNext = txCnt - 1'b1;
    end else if (seqEnd && txCnt != '0) txNext = txCnt - 1'b1;
  end

  // receive counter
  always_comb begin
    rxNext = rxCnt;
    if (ctrl.enterBusOff)             rxNext = '0;
    else if (ctrl.countEn) begin
      if (rxErr) begin
        if (rxCnt != CNT_MAX)         rxNext = rxCnt + 1'b1;
      end else if (rxOk && rxCnt != '0) rxNext = rxCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCnt  <= '0;
      rxCnt  <= '0;
      runCnt <= '0;
      seqCnt <= '0;
    end else begin
      txCnt  <= txNext;
      rxCnt  <= rxNext;
      runCnt <= runNext;
      seqCnt <= seqNext;
    end
  end
endmodule

// File: rtl/canFcCtrl.sv
module canFcCtrl
  import canFcPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    txErr,
  input  logic    txAtMax,
  input  logic    lastSeqDone,
  input  logic    clrResetMode,
  input  logic    ieBusErr,
  input  logic    ieErr,
  output fcCtrl_t ctrl,
  output logic    busOff,
  output logic    resetMode,
  output logic    busErrIrq,
  output logic    errIrq
);
  logic active;

  assign active           = !busOff && !resetMode;
  assign ctrl.countEn     = active;
  assign ctrl.recovEn     = busOff && !resetMode;
  assign ctrl.enterBusOff = active && txErr && txAtMax;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busOff    <= 1'b0;
      resetMode <= 1'b0;
      busErrIrq <= 1'b0;
      errIrq    <= 1'b0;
    end else begin
      if (ctrl.enterBusOff)   busOff <= 1'b1;
      else if (lastSeqDone)   busOff <= 1'b0;
      if (ctrl.enterBusOff)   resetMode <= 1'b1;
      else if (clrResetMode)  resetMode <= 1'b0;
      busErrIrq <= ctrl.enterBusOff && ieBusErr;
      errIrq    <= ctrl.enterBusOff && ieErr;
    end
  end
endmodule

// File: rtl/canFaultConf.sv
module canFaultConf
  import canFcPkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int BUS_FREE_BITS = 11,
  parameter int RECOVER_SEQS  = 128,
  parameter int BUSOFF_LOAD   = 127
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txErr,
  input  logic             rxErr,
  input  logic             txOk,
  input  logic             rxOk,
  input  logic             bitTick,
  input  logic             busLevel,
  input  logic             clrResetMode,
  input  logic             ieBusErr,
  input  logic             ieErr,
  output logic [CNT_W-1:0] txCnt,
  output logic [CNT_W-1:0] rxCnt,
  output logic             busOff,
  output logic             resetMode,
  output logic             busErrIrq,
  output logic             errIrq
);
  fcCtrl_t ctrl;
  logic    txAtMax, lastSeqDone;

  canFcCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .txErr(txErr), .txAtMax(txAtMax),
    .lastSeqDone(lastSeqDone), .clrResetMode(clrResetMode),
    .ieBusErr(ieBusErr), .ieErr(ieErr), .ctrl(ctrl),
    .busOff(busOff), .resetMode(resetMode),
    .busErrIrq(busErrIrq), .errIrq(errIrq)
  );

  canFcData #(
    .CNT_W(CNT_W), .BUS_FREE_BITS(BUS_FREE_BITS),
    .RECOVER_SEQS(RECOVER_SEQS), .BUSOFF_LOAD(BUSOFF_LOAD)
  ) i_data (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .txErr(txErr), .rxErr(rxErr), .txOk(txOk), .rxOk(rxOk),
    .bitTick(bitTick), .busLevel(busLevel),
    .txCnt(txCnt), .rxCnt(rxCnt),
    .txAtMax(txAtMax), .lastSeqDone(lastSeqDone)
  );
endmodule

// File: rtl/canFcChecker.sv
module canFcChecker #(
  parameter int CNT_W       = 8,
  parameter int BUSOFF_LOAD = 127
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] txCnt,
  input logic [CNT_W-1:0] rxCnt,
  input logic             busOff,
  input logic             resetMode,
  input logic             busErrIrq,
  input logic             errIrq,
  input logic             ieBusErr,
  input logic             ieErr
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSOFF_LOAD);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  p_busoff_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOff) |-> (txCnt == LOAD_VAL && rxCnt == '0 && resetMode));

  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busErrIrq || errIrq) |=> (!busErrIrq && !errIrq));

  p_irq_at_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busErrIrq || errIrq) |-> $rose(busOff));

  p_irq_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busErrIrq |-> $past(ieBusErr)) and (errIrq |-> $past(ieErr)));

  p_frozen_reset_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    resetMode |=> ($stable(txCnt) && $stable(rxCnt)));

  p_rx_no_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(busOff) |-> (rxCnt == $past(rxCnt) || rxCnt == $past(rxCnt) + 1'b1
                        || rxCnt == $past(rxCnt) - 1'b1)
                       && !($past(rxCnt) == '0 && rxCnt == CNT_MAX)
                       && !($past(rxCnt) == CNT_MAX && rxCnt == '0));

  p_exit_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOff) |-> (txCnt == '0 && !resetMode));
endmodule

bind canFaultConf canFcChecker #(.CNT_W(CNT_W), .BUSOFF_LOAD(BUSOFF_LOAD)) i_canFcChecker (
  .clk(clk), .rstN(rstN), .txCnt(txCnt), .rxCnt(rxCnt), .busOff(busOff),
  .resetMode(resetMode), .busErrIrq(busErrIrq), .errIrq(errIrq),
  .ieBusErr(ieBusErr), .ieErr(ieErr)
);

// File: tb/test_canFaultConf.sv
`timescale 1ns/1ps
module test_canFaultConf;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txErr = 0, rxErr = 0, txOk = 0, rxOk = 0;
  logic bitTick = 0, busLevel = 1, clrResetMode = 0, ieBusErr = 0, ieErr = 0;
  logic [7:0] txCnt, rxCnt;
  logic busOff, resetMode, busErrIrq, errIrq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  canFaultConf i_canFaultConf (
    .clk(clk), .rstN(rstN), .txErr(txErr), .rxErr(rxErr), .txOk(txOk), .rxOk(rxOk),
    .bitTick(bitTick), .busLevel(busLevel), .clrResetMode(clrResetMode),
    .ieBusErr(ieBusErr), .ieErr(ieErr), .txCnt(txCnt), .rxCnt(rxCnt),
    .busOff(busOff), .resetMode(resetMode), .busErrIrq(busErrIrq), .errIrq(errIrq)
  );

  // {txErr, rxErr, txOk, rxOk, expected txCnt, expected rxCnt}
  localparam logic [19:0] VEC [15] = '{
    {4'b1000, 8'd1, 8'd0}, {4'b1000, 8'd2, 8'd0}, {4'b0100, 8'd2, 8'd1},
    {4'b1100, 8'd3, 8'd2}, {4'b0010, 8'd2, 8'd2}, {4'b0001, 8'd2, 8'd1},
    {4'b1010, 8'd3, 8'd1}, {4'b0101, 8'd3, 8'd2}, {4'b0001, 8'd3, 8'd1},
    {4'b0001, 8'd3, 8'd0}, {4'b0001, 8'd3, 8'd0}, {4'b0010, 8'd2, 8'd0},
    {4'b0010, 8'd1, 8'd0}, {4'b0010, 8'd0, 8'd0}, {4'b0010, 8'd0, 8'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // inputs are set at a falling edge; sample at the next falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    txErr = 0; rxErr = 0; txOk = 0; rxOk = 0; bitTick = 0; busLevel = 1; clrResetMode = 0;
  endtask

  task automatic bits(input int n, input logic lvl);
    for (int k = 0; k < n; k++) begin
      bitTick = 1; busLevel = lvl; tick();
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "txCnt", txCnt, 0); chk("R1", "rxCnt", rxCnt, 0);
    chk("R1", "flags", {busOff, resetMode, busErrIrq, errIrq}, 0);
    rstN = 1;
    @(negedge clk);

    // R2 table walk
    for (int i = 0; i < 15; i++) begin
      {txErr, rxErr, txOk, rxOk} = VEC[i][19:16];
      tick();
      chk("R2", $sformatf("vec%0d txCnt", i), txCnt, VEC[i][15:8]);
      chk("R2", $sformatf("vec%0d rxCnt", i), rxCnt, VEC[i][7:0]);
    end

    // R6 clear while not in reset mode
    clrResetMode = 1; tick();
    chk("R6", "resetMode idle clear", resetMode, 0);
    chk("R6", "txCnt idle clear", txCnt, 0);

    // R2 receive saturation at 255
    for (int i = 0; i < 260; i++) begin rxErr = 1; tick(); end
    chk("R2", "rxCnt saturate", rxCnt, 255);

    // R3 climb to 254 then 255
    for (int i = 0; i < 254; i++) begin txErr = 1; tick(); end
    chk("R3", "txCnt at 254", txCnt, 254);
    txErr = 1; tick();
    chk("R3", "txCnt at 255", txCnt, 255);
    chk("R3", "busOff before", busOff, 0);

    // R3/R4 entry
    txErr = 1; ieBusErr = 1; ieErr = 0; tick();
    ieBusErr = 0;
    chk("R3", "busOff", busOff, 1); chk("R3", "resetMode", resetMode, 1);
    chk("R3", "txCnt load", txCnt, 127); chk("R3", "rxCnt clear", rxCnt, 0);
    chk("R4", "busErrIrq", busErrIrq, 1); chk("R4", "errIrq gated", errIrq, 0);
    tick();
    chk("R4", "busErrIrq one cycle", busErrIrq, 0);

    // R5 strobes ignored in reset mode
    txErr = 1; rxErr = 1; tick();
    txOk = 1; rxOk = 1; tick();
    chk("R5", "txCnt frozen", txCnt, 127); chk("R5", "rxCnt frozen", rxCnt, 0);
    // R7 ticks ignored in reset mode
    bits(30, 1'b1);
    chk("R7", "no recovery in reset mode", txCnt, 127);

    // R6 software clear
    clrResetMode = 1; tick();
    chk("R6", "resetMode cleared", resetMode, 0);
    chk("R6", "still bus-off", busOff, 1);

    // R5 strobes ignored during bus-off
    txErr = 1; rxErr = 1; tick();
    chk("R5", "txCnt in bus-off", txCnt, 127); chk("R5", "rxCnt in bus-off", rxCnt, 0);

    // R8 dominant bit restarts the run
    bits(10, 1'b1); bits(1, 1'b0); bits(10, 1'b1);
    chk("R8", "txCnt after broken run", txCnt, 127);
    bits(1, 1'b1);
    chk("R7", "txCnt after first run", txCnt, 126);

    // R7/R9 remaining runs
    for (int s = 0; s < 126; s++) bits(11, 1'b1);
    chk("R7", "txCnt after 127 runs", txCnt, 0);
    chk("R9", "busOff after 127 runs", busOff, 1);
    bits(10, 1'b1);
    chk("R9", "busOff mid final run", busOff, 1);
    bits(1, 1'b1);
    chk("R9", "busOff after 128 runs", busOff, 0);
    chk("R9", "txCnt after exit", txCnt, 0);
    txErr = 1; tick();
    chk("R9", "counting resumes", txCnt, 1);

    // R4 second entry with the other enable
    for (int i = 0; i < 254; i++) begin txErr = 1; tick(); end
    txErr = 1; ieErr = 1; tick();
    ieErr = 0;
    chk("R4", "errIrq", errIrq, 1); chk("R4", "busErrIrq gated", busErrIrq, 0);
    chk("R3", "second entry", busOff, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule